// File: doc/BRIEF.md
# Programmable Integer Clock Divider

This block divides an input clock by a programmable integer ratio. It serves both a system clock and a pixel clock. An 8-bit setup value selects the ratio, which is the setup value plus one, so the range runs from 1 to 256. When the ratio is even, the output has a 1:1 duty. When the ratio is odd, the high phase is one input cycle shorter than the low phase: it lasts floor(N/2) input cycles, and the low phase takes the rest. A setup value of zero passes the input clock straight through. A control input inverts the output, which is useful when the pixel clock must be launched on the opposite edge.

A new setup value is taken only in the last input cycle of the current output period, so a change never cuts a pulse short. A terminal-count strobe marks that last cycle, and downstream logic can use it as a clock-enable at the divided rate. The design has an active-low asynchronous reset and a synchronous clear input. Both leave the counter at zero and the output low. The first period starts, with its high phase, at the first clock edge after reset is released.

Top module: `clkdiv_top`

## Requirements
- R1: The output period equals setup+1 cycles of `clk_i`, where setup is the value in force for that period.
- R2: For an even ratio N, `clk_o` (with invert 0) is high for N/2 cycles and then low for N/2 cycles.
- R3: For an odd ratio N ≥ 3, `clk_o` is high for floor(N/2) cycles first and then low for the remaining cycles. For example, N=3 gives 1 high and 2 low, N=5 gives 2 high and 3 low, and N=7 gives 3 high and 4 low.
- R4: With setup 0, `clk_o` follows `clk_i` in both of its phases, and `tc_o` is high in every cycle.
- R5: When `invert_i`=1, `clk_o` is the logical complement of its non-inverted value, and the change takes effect at once.
- R6: A change of `setup_i` is taken only at an edge where `tc_o` is high. A period that is already running completes with its old ratio.
- R7: While `rst_ni` is low, `clk_o` is low (when `invert_i`=0) and `tc_o` is low.
- R8: At an edge where `srst_i`=1, the divider clears: `clk_o` is low (when `invert_i`=0) and `tc_o` is low until the first edge with `srst_i`=0. At that edge a new period starts with its high phase, using the current `setup_i`.
- R9: `tc_o` is high exactly during the last `clk_i` cycle of each output period.
- R10: Setup 255 gives a ratio of 256, with 128 cycles high and 128 cycles low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous clear, active high |
| setup_i | input | 8 | Division setup value; ratio is setup_i+1 |
| invert_i | input | 1 | Inverts clk_o when 1 |
| clk_o | output | 1 | Divided clock |
| tc_o | output | 1 | High in the last input cycle of each output period |

## Verification
The bench runs the divider with even ratios (2, 4) and odd ratios (3, 5, 7) and compares `clk_o` and `tc_o` against a reference in every input cycle. This tells a correct floor(N/2) high phase apart from a rounded-up high phase or a 1:1 duty. Setup 0 is checked in both clock phases to prove the clock passes through, and inversion is checked with both a divided clock and the passed-through clock. A setup change made in the middle of a period, a synchronous clear in the middle of a period, and the full ratio of 256 show that the ratio is loaded only at the period boundary and that the counter covers its full range.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  parameter int unsigned SETUP_W_DEF = 8;
endpackage

// File: rtl/clkdiv_ratio_reg.sv
module clkdiv_ratio_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         tc_i,
  input  logic [W-1:0] setup_i,
  output logic [W-1:0] act_q_o,
  output logic [W-1:0] act_nxt_o
);
  always_comb begin
    if (srst_i)    act_nxt_o = '0;
    else if (tc_i) act_nxt_o = setup_i;
    else           act_nxt_o = act_q_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q_o <= '0;
    else         act_q_o <= act_nxt_o;
  end

  // R6: ratio held through a running period
  p_hold_midperiod_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tc_i && !srst_i) |=> $stable(act_q_o));
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic [W-1:0] act_i,
  output logic [W-1:0] cnt_q_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         tc_o
);
  assign tc_o = (cnt_q_o == act_i);

  always_comb begin
    if (srst_i || tc_o) cnt_nxt_o = '0;
    else                cnt_nxt_o = cnt_q_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q_o <= '0;
    else         cnt_q_o <= cnt_nxt_o;
  end

  p_cnt_in_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q_o <= act_i);
  p_wrap_after_tc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !srst_i) |=> (cnt_q_o == '0));
endmodule

// File: rtl/clkdiv_wave.sv
module clkdiv_wave #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cnt_nxt_i,
  input  logic [W-1:0] act_nxt_i,
  output logic         q_o
);
  localparam int unsigned HW = W + 1;

  logic [HW-1:0] half_len;
  logic          q_nxt;

  // high phase length floor(N/2), N = act+1
  assign half_len = ({1'b0, act_nxt_i} + 1'b1) >> 1;
  assign q_nxt    = !srst_i && ({1'b0, cnt_nxt_i} < half_len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_nxt;
  end

  // R3: high phase always opens a period
  p_rise_at_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> (cnt_i == '0));
  p_low_after_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(srst_i) |-> !q_o);
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top #(
  parameter int unsigned SETUP_W = clkdiv_pkg::SETUP_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               srst_i,
  input  logic [SETUP_W-1:0] setup_i,
  input  logic               invert_i,
  output logic               clk_o,
  output logic               tc_o
);
  logic [SETUP_W-1:0] act_q, act_nxt, cnt_q, cnt_nxt;
  logic               tc_raw, q, run_q, pass, base;

  clkdiv_ratio_reg #(.W(SETUP_W)) u_ratio (
    .clk_i, .rst_ni, .srst_i,
    .tc_i      (tc_raw),
    .setup_i,
    .act_q_o   (act_q),
    .act_nxt_o (act_nxt)
  );

  clkdiv_counter #(.W(SETUP_W)) u_cnt (
    .clk_i, .rst_ni, .srst_i,
    .act_i     (act_q),
    .cnt_q_o   (cnt_q),
    .cnt_nxt_o (cnt_nxt),
    .tc_o      (tc_raw)
  );

  clkdiv_wave #(.W(SETUP_W)) u_wave (
    .clk_i, .rst_ni, .srst_i,
    .cnt_i     (cnt_q),
    .cnt_nxt_i (cnt_nxt),
    .act_nxt_i (act_nxt),
    .q_o       (q)
  );

  // run_q masks outputs until the first active edge after any reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= !srst_i;
  end

  assign pass  = (act_q == '0);
  assign base  = run_q && (pass ? clk_i : q);
  assign clk_o = base ^ invert_i;
  assign tc_o  = run_q && tc_raw;

  p_tc_quiet_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !tc_o);
  p_pass_tc_every_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && pass) |-> tc_o);
endmodule

// File: tb/sim_clkdiv_top.sv
`timescale 1ns/1ps
module sim_clkdiv_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       srst_i = 1'b0;
  logic [7:0] setup_i = 8'd1;
  logic       invert_i = 1'b0;
  logic       clk_o, tc_o;

  always #2.5 clk_i = ~clk_i;

  clkdiv_top u0 (.clk_i, .rst_ni, .srst_i, .setup_i, .invert_i, .clk_o, .tc_o);

  typedef struct {
    logic  hi;
    logic  lo;
    logic  tc;
    string tag;
  } item_t;

  item_t sb[$];
  int n_run = 0;
  int n_fail = 0;

  int m_cnt = 0, m_act = 0;
  bit m_run = 0;
  int prev_setup = 1;
  bit prev_srst = 0;

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // driver: advance reference across one edge, apply new inputs, push expectation
  task automatic step(input int s, input bit inv, input bit sr, input string tag);
    item_t it;
    logic bh, bl;
    @(posedge clk_i);
    #0.5;
    if (prev_srst) begin
      m_cnt = 0; m_act = 0; m_run = 0;
    end else begin
      if (m_cnt == m_act) begin m_act = prev_setup; m_cnt = 0; end
      else m_cnt++;
      m_run = 1;
    end
    setup_i = 8'(s); invert_i = inv; srst_i = sr;
    prev_setup = s; prev_srst = sr;
    if (!m_run) begin bh = 0; bl = 0; end
    else if (m_act == 0) begin bh = 1; bl = 0; end
    else begin bh = (m_cnt < (m_act + 1) / 2); bl = bh; end
    it.hi = bh ^ inv; it.lo = bl ^ inv;
    it.tc = m_run && (m_cnt == m_act);
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic run(input int n, input int s, input bit inv, input string tag);
    for (int i = 0; i < n; i++) step(s, inv, 1'b0, tag);
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(posedge clk_i);
      #1;
      if (sb.size() != 0) begin
        it = sb.pop_front();
        check(clk_o, it.hi, it.tag, "clk_o high phase");
        check(tc_o, it.tc, "R9", "tc_o");
        #2.5;
        check(clk_o, it.lo, it.tag, "clk_o low phase");
      end
    end
  end

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    #12;
    check(clk_o, 1'b0, "R7", "clk_o in reset");
    check(tc_o, 1'b0, "R7", "tc_o in reset");
    #2.5;
    check(clk_o, 1'b0, "R7", "clk_o in reset other phase");
    @(posedge clk_i); #0.5;
    rst_ni = 1'b1;

    run(12, 1, 0, "R2");       // N=2
    run(16, 3, 0, "R2");       // N=4
    run(15, 2, 0, "R3");       // N=3
    run(20, 4, 0, "R3");       // N=5
    run(28, 6, 0, "R3");       // N=7
    run(8,  0, 0, "R4");       // pass-through
    run(12, 2, 1, "R5");       // inverted N=3
    run(6,  0, 1, "R5");       // inverted pass-through
    run(10, 7, 0, "R1");       // N=8
    run(3,  7, 0, "R1");
    run(20, 1, 0, "R6");       // change mid-period
    run(5,  5, 0, "R8");
    step(5, 0, 1, "R8");
    step(5, 0, 1, "R8");
    run(14, 5, 0, "R8");
    run(600, 255, 0, "R10");
    repeat (3) @(posedge clk_i);
    finish_up();
  end
endmodule